// File: doc/BRIEF.md
# Bit-Field Insert Unit

This combinational datapath block deposits the low-order bits of a source word into a contiguous field of a destination word. It is intended for an ALU's field-insert operation.

The field is described by two unsigned codes:
- a low bit position, `fld_lo`;
- a length-minus-one code, `fld_len_m1`, so that the field's top bit is `fld_lo + fld_len_m1`.

Destination bits outside the field reach the result unchanged. Source bit 0 lands on the field's low bit, and each higher field bit takes the next higher source bit.

The result is formed without a per-bit priority loop. A logarithmic left shifter aligns the source. A second shifter moves a thermometer-coded field mask into place. A plain AND/OR merge then combines the two. A field that would run past the most significant bit is clipped there, and source bits that would land beyond it are dropped.

Top module: `bfi_unit`

## Requirements
- R1: Every result bit below position `fld_lo` equals the same bit of `ins_dst`.
- R2: When `fld_lo + fld_len_m1` is below 31, every result bit above that sum equals the same bit of `ins_dst`.
- R3: For each k from 0 to `fld_len_m1` with `fld_lo + k` at most 31, result bit `fld_lo + k` equals `ins_src` bit k.
- R4: With `fld_lo` = 0 and `fld_len_m1` = 31, the result equals `ins_src` in full.
- R5: When `fld_lo + fld_len_m1` exceeds 31, the field is clipped. Result bits `fld_lo` to 31 take `ins_src` bits 0 upward, and no source bit appears anywhere else.
- R6: With `fld_len_m1` = 0, only result bit `fld_lo` is taken from `ins_src` (its bit 0). All other bits come from `ins_dst`.
- R7: The block holds no state. The result follows any change of the inputs within the same clock period, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ins_src | input | 32 | Word whose low bits are inserted |
| ins_dst | input | 32 | Word that receives the field |
| fld_lo | input | 5 | Bit position of the field's low end |
| fld_len_m1 | input | 5 | Field length minus one |
| ins_out | output | 32 | Destination with the field replaced |

## Verification
Every result is due in the same cycle as its operands, zero clock edges later, because no register lies between any input and `ins_out`. The bench drives a new operand set just after a rising edge and samples `ins_out` two nanoseconds later. This falls well inside the same 10 ns period, before the next edge can change anything. The sweep covers all 1024 position and length pairs, each with several operand patterns. Each vector is checked separately on three regions: below the field, the field itself, and above the field.

// File: rtl/bfi_pkg.sv
package bfi_pkg;

    parameter int unsigned DATA_W = 32;
    localparam int unsigned POS_W = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;

    // Operand bundle carried from the ports into the datapath
    typedef struct packed {
        word_t src;
        word_t dst;
        pos_t  lo;
        pos_t  len_m1;
    } bfi_req_t;

    // Intermediate values produced ahead of the merge stage
    typedef struct packed {
        word_t aligned_src;
        word_t field_mask;
    } bfi_mid_t;

    // Merge of aligned source and destination under a mask
    function automatic word_t bfi_blend(word_t dst, word_t aligned, word_t mask);
        return (dst & ~mask) | (aligned & mask);
    endfunction

endpackage

// File: rtl/bfi_lshift.sv
module bfi_lshift #(
    parameter int unsigned W    = 32,
    parameter int unsigned SH_W = 5
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    // One mux rank per shift-amount bit: depth grows with log2(W)
    for (genvar s = 0; s < SH_W; s++) begin : g_rank
        assign stage[s+1] = amt[s] ? (stage[s] << (2**s)) : stage[s];
    end

    assign dout = stage[SH_W];
endmodule

// File: rtl/bfi_mask_gen.sv
module bfi_mask_gen #(
    parameter int unsigned W     = 32,
    parameter int unsigned POS_W = 5
) (
    input  logic [POS_W-1:0] lo,
    input  logic [POS_W-1:0] len_m1,
    output logic [W-1:0]     mask
);
    logic [W-1:0] thermo;

    // Thermometer code: bit i set when i <= len_m1 (len_m1 = W-1 gives all ones)
    for (genvar i = 0; i < W; i++) begin : g_thermo
        assign thermo[i] = (len_m1 >= POS_W'(i));
    end

    // Bits pushed beyond the MSB fall off: this is the clipping of oversize fields
    bfi_lshift #(.W(W), .SH_W(POS_W)) u_mask_sh (
        .din  (thermo),
        .amt  (lo),
        .dout (mask)
    );
endmodule

// File: rtl/bfi_merge.sv
module bfi_merge
    import bfi_pkg::*;
(
    input  word_t    dst,
    input  bfi_mid_t mid,
    output word_t    result
);
    assign result = bfi_blend(dst, mid.aligned_src, mid.field_mask);
endmodule

// File: rtl/bfi_unit.sv
module bfi_unit
    import bfi_pkg::*;
#(
    parameter int unsigned DW = bfi_pkg::DATA_W,
    parameter int unsigned PW = bfi_pkg::POS_W
) (
    input  logic [DW-1:0] ins_src,
    input  logic [DW-1:0] ins_dst,
    input  logic [PW-1:0] fld_lo,
    input  logic [PW-1:0] fld_len_m1,
    output logic [DW-1:0] ins_out
);
    bfi_req_t req;
    bfi_mid_t mid;

    assign req.src    = ins_src;
    assign req.dst    = ins_dst;
    assign req.lo     = fld_lo;
    assign req.len_m1 = fld_len_m1;

    // Source alignment: left barrel shift by the field's low position
    bfi_lshift #(.W(DW), .SH_W(PW)) u_src_sh (
        .din  (req.src),
        .amt  (req.lo),
        .dout (mid.aligned_src)
    );

    // Field mask, built alongside the source shift in parallel
    bfi_mask_gen #(.W(DW), .POS_W(PW)) u_mask (
        .lo     (req.lo),
        .len_m1 (req.len_m1),
        .mask   (mid.field_mask)
    );

    bfi_merge u_merge (
        .dst    (req.dst),
        .mid    (mid),
        .result (ins_out)
    );
endmodule

// File: rtl/bfi_unit_chk.sv
module bfi_unit_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 5
) (
    input logic [DW-1:0] ins_src,
    input logic [DW-1:0] ins_dst,
    input logic [PW-1:0] fld_lo,
    input logic [PW-1:0] fld_len_m1,
    input logic [DW-1:0] ins_out
);
    localparam int TW = PW + 1;

    logic [TW-1:0] top_sum;
    logic [TW-1:0] top_clip;
    logic [TW-1:0] fld_w;
    logic [DW-1:0] diff;
    logic          below_ok, above_ok, field_ok, full_ok;

    assign top_sum  = {1'b0, fld_lo} + {1'b0, fld_len_m1};
    assign top_clip = (top_sum > TW'(DW-1)) ? TW'(DW-1) : top_sum;
    assign fld_w    = top_clip - {1'b0, fld_lo} + TW'(1);
    assign diff     = ins_out ^ ins_dst;

    assign below_ok = (fld_lo == '0) || ((diff << (DW - int'(fld_lo))) == '0);
    assign above_ok = (top_sum >= TW'(DW-1)) || ((diff >> (int'(top_sum) + 1)) == '0);
    assign field_ok = ((((ins_out >> fld_lo) ^ ins_src) << (DW - int'(fld_w))) == '0);
    assign full_ok  = !((fld_lo == '0) && (fld_len_m1 == PW'(DW-1))) || (ins_out == ins_src);

    always_comb begin
        AST_BELOW_KEEP: assert (below_ok) else $error("bits below field changed"); // R1
        AST_ABOVE_KEEP: assert (above_ok) else $error("bits above field changed"); // R2
        AST_FIELD_SRC:  assert (field_ok) else $error("field bits differ from source"); // R3
        AST_FULL_WORD:  assert (full_ok)  else $error("full-width insert differs"); // R4
    end
endmodule

bind bfi_unit bfi_unit_chk #(.DW(DW), .PW(PW)) u_chk (.*);

// File: tb/bfi_unit_tb.sv
module bfi_unit_tb;
    logic        clk = 1'b0;
    logic [31:0] ins_src = '0;
    logic [31:0] ins_dst = '0;
    logic [4:0]  fld_lo = '0;
    logic [4:0]  fld_len_m1 = '0;
    logic [31:0] ins_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bfi_unit u_dut (
        .ins_src    (ins_src),
        .ins_dst    (ins_dst),
        .fld_lo     (fld_lo),
        .fld_len_m1 (fld_len_m1),
        .ins_out    (ins_out)
    );

    function automatic logic [31:0] ref_val(logic [31:0] s, logic [31:0] d, int lo, int len);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i <= lo + len) r[i] = s[i - lo];
            else                          r[i] = d[i];
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp, logic [31:0] sel);
        n_chk++;
        if (((got ^ exp) & sel) != 32'h0) begin
            n_err++;
            $display("FAIL %s lo=%0d len_m1=%0d actual=%h expected=%h (bits %h)",
                     req, fld_lo, fld_len_m1, got, exp, sel);
        end
    endtask

    task automatic run_vec(logic [31:0] s, logic [31:0] d, int lo, int len);
        logic [31:0] exp, m_lo, m_fld, m_hi;
        string fld_req;
        @(posedge clk);
        ins_src = s; ins_dst = d; fld_lo = 5'(lo); fld_len_m1 = 5'(len);
        exp = ref_val(s, d, lo, len);
        for (int i = 0; i < 32; i++) begin
            m_lo[i]  = (i < lo);
            m_fld[i] = (i >= lo && i <= lo + len);
            m_hi[i]  = (i > lo + len);
        end
        if (lo == 0 && len == 31)  fld_req = "R4";
        else if (lo + len > 31)    fld_req = "R5";
        else if (len == 0)         fld_req = "R6";
        else                       fld_req = "R3";
        #2;
        check("R1", ins_out, exp, m_lo);
        check(fld_req, ins_out, exp, m_fld);
        check("R2", ins_out, exp, m_hi);
    endtask

    initial begin
        // Initial state: all-zero operands give a zero result
        #2;
        check("R7", ins_out, 32'h0, 32'hFFFF_FFFF);

        // R7: change inputs with no clock edge in between; the result follows at once
        @(negedge clk);
        ins_src = 32'h0000_00A5; ins_dst = 32'hFFFF_0000; fld_lo = 5'd4; fld_len_m1 = 5'd7;
        #1;
        check("R7", ins_out, 32'hFFFF_0A50, 32'hFFFF_FFFF);
        fld_lo = 5'd8;
        #1;
        check("R7", ins_out, 32'hFFFF_A500, 32'hFFFF_FFFF);

        // R4: a full-width insert replaces the destination entirely
        run_vec(32'h1234_5678, 32'hDEAD_BEEF, 0, 31);

        // R6: a single-bit field at the top and at the bottom
        run_vec(32'hFFFF_FFFF, 32'h0000_0000, 31, 0);
        run_vec(32'h0000_0000, 32'hFFFF_FFFF, 0, 0);

        // R5: a clipped field drops the high source bits
        run_vec(32'hFFFF_FFFF, 32'h0000_0000, 28, 10);

        // Sweep of every position and length pair with several operand patterns
        for (int lo = 0; lo < 32; lo++) begin
            for (int len = 0; len < 32; len++) begin
                run_vec(32'hFFFF_FFFF, 32'h0000_0000, lo, len);
                run_vec(32'h0000_0000, 32'hFFFF_FFFF, lo, len);
                run_vec($urandom, $urandom, lo, len);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule